// File: doc/BRIEF.md
# SPI Command Engine with Shared Ring Buffer

This block is a register-driven SPI master that issues one command at a time to a serial flash device. Software stores an opcode in a dedicated register, packs the number of bytes to send after the opcode and the number of bytes to collect into one count register, and loads the outgoing bytes through a data port. A start bit then launches the transfer. Chip select stays low for the whole exchange, the opcode goes out first, then the stored bytes, and then filler bytes while the response is clocked in.

Outgoing and incoming bytes live in one small circular buffer whose contents are never cleared. Every byte clocked in after the opcode is stored in the slot whose outgoing byte was just sent, so a response begins right after the echoed transmit slots. Software rewinds the buffer pointer, skips the echo slots and reads the response through the same data port. The pointer is visible in the status register.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, chip select (`spi_cs_n`) is high, `spi_sck` is low, and the status register (address 4) reads 0: pointer 0, busy bit 6 clear, done bit 7 clear.
- R2: The opcode held in register address 0 is always the first byte shifted out in a transaction. It is never stored in the ring buffer.
- R3: Register address 1 holds the receive byte count in bits 7:4 and the transmit byte count, not counting the opcode, in bits 3:0. It reads back as written.
- R4: Each write or read of the data port (address 2) transfers the ring slot at the pointer and then advances the pointer by one, modulo 8. The pointer reads back in status bits 2:0.
- R5: Writing 1 to bit 1 of the control register (address 3) sets the pointer to 0 and leaves the ring contents unchanged.
- R6: For the k-th byte after the opcode (k counted from 0), the engine sends ring slot k mod 8 while k is below the transmit count and 0xFF after that. It stores the byte received during that byte time into slot k mod 8. A transaction does not move the software pointer.
- R7: With a transmit count of zero, every requested receive byte, including the last, is stored before chip select rises.
- R8: Chip select is low from the start until the last byte is stored, and SCK pulses only while chip select is low. When busy (status bit 6) clears, chip select is high and done (status bit 7) is set. Writing 1 to control bit 0 sets busy and clears done.
- R9: Transfers use SPI mode 0 and send the most significant bit first. MOSI changes only while SCK is low, and MISO is sampled at the rising SCK edge.
- R10: While busy, writes to the opcode, count, data port and divider registers, and start requests, are ignored.
- R11: When the transmit count plus the receive count exceeds 8, later bytes overwrite earlier ring slots. No error is raised.
- R12: Each SCK high phase and each SCK low phase inside a byte lasts D+1 system clocks, where D is the divider register (address 5, bits 3:0, reset value 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_rd | input | 1 | Register read strobe. A data-port read advances the pointer |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
The hardest cases to reach are register writes that land during a running transaction and frames longer than the ring. The bench starts a long receive-only frame with a slow divider, then issues opcode, count, data, divider and start writes while busy is still high. After completion it reads those registers back and checks the pointer. It also runs an 11-byte frame so that late response bytes overwrite echo slots. The bench keeps its own model of all eight slots and compares a full ring dump after every frame. A device model checks each MOSI byte against a scoreboard queue and counts the bytes inside each chip-select window.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

   localparam logic [2:0] ADDR_OPC = 3'd0;
   localparam logic [2:0] ADDR_CNT = 3'd1;
   localparam logic [2:0] ADDR_DAT = 3'd2;
   localparam logic [2:0] ADDR_CTL = 3'd3;
   localparam logic [2:0] ADDR_STA = 3'd4;
   localparam logic [2:0] ADDR_DIV = 3'd5;

   localparam int CTL_START = 0;
   localparam int CTL_PRST  = 1;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_OPC  = 2'd1,
      SEQ_XFER = 2'd2
   } seq_state_e;

endpackage

// File: rtl/spi_eng_tick.sv
module spi_eng_tick #(
   parameter int DIV_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);

   generate
      if (DIV_W < 1) begin : g_bad_div
         $error("spi_eng_tick: DIV_W must be at least 1");
      end
   endgenerate

   logic [DIV_W-1:0] cnt_q;

   assign tick = run && (cnt_q == div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run || tick) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R12: the counter never runs past the programmed divider value
   a_r12_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      run && $stable(div) && $past(run) |-> cnt_q <= div);

endmodule

// File: rtl/spi_eng_shift.sv
module spi_eng_shift #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   input  logic              miso,
   output logic              sck,
   output logic              mosi,
   output logic              byte_done,
   output logic [DATA_W-1:0] rx_data
);

   localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("spi_eng_shift: DATA_W must be at least 2");
      end
   endgenerate

   logic              active_q;
   logic [BW-1:0]     bit_q;
   logic [DATA_W-1:0] out_q;
   logic [DATA_W-1:0] in_q;

   assign mosi    = out_q[DATA_W-1];
   assign rx_data = in_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q  <= 1'b0;
         bit_q     <= '0;
         out_q     <= '0;
         in_q      <= '0;
         sck       <= 1'b0;
         byte_done <= 1'b0;
      end else begin
         byte_done <= 1'b0;
         if (load) begin
            active_q <= 1'b1;
            bit_q    <= '0;
            out_q    <= load_data;
            sck      <= 1'b0;
         end else if (tick && active_q) begin
            if (!sck) begin
               sck  <= 1'b1;
               in_q <= {in_q[DATA_W-2:0], miso};
            end else begin
               sck <= 1'b0;
               if (bit_q == LAST_BIT) begin
                  active_q  <= 1'b0;
                  byte_done <= 1'b1;
               end else begin
                  out_q <= {out_q[DATA_W-2:0], 1'b0};
                  bit_q <= bit_q + 1'b1;
               end
            end
         end
      end
   end

   // R9: mode 0, so MOSI may only move while SCK is low
   a_r9_mosi_steady: assert property (@(posedge clk) disable iff (!rst_n)
      sck |-> $stable(mosi));
   // R9: SCK only toggles inside an active byte
   a_r9_sck_active: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sck) |-> active_q);

endmodule

// File: rtl/spi_eng_ring.sv
module spi_eng_ring #(
   parameter int DATA_W = 8,
   parameter int PTR_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_clr,
   input  logic              sw_adv,
   input  logic              sw_wr,
   input  logic [DATA_W-1:0] sw_wdata,
   output logic [DATA_W-1:0] sw_rdata,
   output logic [PTR_W-1:0]  ptr,
   input  logic              eng_wr,
   input  logic [PTR_W-1:0]  eng_idx,
   input  logic [DATA_W-1:0] eng_wdata,
   input  logic [PTR_W-1:0]  eng_rd_idx,
   output logic [DATA_W-1:0] eng_rdata
);

   localparam int DEPTH = 1 << PTR_W;

   generate
      if (PTR_W < 1 || PTR_W > 6) begin : g_bad_ptr
         $error("spi_eng_ring: PTR_W must be between 1 and 6");
      end
   endgenerate

   logic [DATA_W-1:0] mem_q [DEPTH];

   assign sw_rdata  = mem_q[ptr];
   assign eng_rdata = mem_q[eng_rd_idx];

   // contents carry no reset: the ring is never cleared
   always_ff @(posedge clk) begin
      if (eng_wr) begin
         mem_q[eng_idx] <= eng_wdata;
      end else if (sw_wr) begin
         mem_q[ptr] <= sw_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr <= '0;
      end else if (sw_clr) begin
         ptr <= '0;
      end else if (sw_adv) begin
         ptr <= ptr + 1'b1;
      end
   end

   // R4: every data-port access steps the pointer by one, wrapping
   a_r4_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
      sw_adv && !sw_clr |=> ptr == $past(ptr) + 1'b1);
   // R5: a pointer reset leaves the slot under the old pointer intact
   a_r5_clr_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      sw_clr && !sw_wr && !eng_wr |=> mem_q[$past(ptr)] == $past(sw_rdata));
   // R6: engine and software never write the ring in the same cycle
   a_r6_one_writer: assert property (@(posedge clk) disable iff (!rst_n)
      !(eng_wr && sw_wr));

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
   import spi_eng_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int CNT_W   = 4,
   parameter int PTR_W   = 3,
   parameter int DIV_W   = 4,
   parameter int DIV_RST = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        reg_addr,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              spi_sck,
   output logic              spi_cs_n,
   output logic              spi_mosi,
   input  logic              spi_miso
);

   localparam int IDX_W = CNT_W + 1;
   localparam int PAD_W = DATA_W - 2 - PTR_W;

   generate
      if (2 * CNT_W != DATA_W) begin : g_bad_cnt
         $error("spi_cmd_engine: the count register must hold two CNT_W fields");
      end
      if (PAD_W < 1) begin : g_bad_sta
         $error("spi_cmd_engine: status register too narrow for pointer and flags");
      end
      if (DIV_W >= DATA_W) begin : g_bad_div
         $error("spi_cmd_engine: DIV_W must be narrower than DATA_W");
      end
   endgenerate

   seq_state_e        state_q;
   logic [DATA_W-1:0] opcode_q;
   logic [CNT_W-1:0]  tx_cnt_q, rx_cnt_q;
   logic [DIV_W-1:0]  div_q;
   logic [IDX_W-1:0]  idx_q, nxt_idx, total;
   logic              busy_q, done_q, last;
   logic              wr_ok, start, ptr_clr, sw_wr, sw_adv;
   logic              tick, ld_en, byte_done, eng_wr;
   logic [DATA_W-1:0] ld_data, rx_byte, sw_rdata, eng_rdata;
   logic [PTR_W-1:0]  ptr, eng_rd_idx;

   // register decode
   assign wr_ok   = reg_wr && !busy_q;
   assign start   = wr_ok && (reg_addr == ADDR_CTL) && reg_wdata[CTL_START];
   assign ptr_clr = reg_wr && (reg_addr == ADDR_CTL) && reg_wdata[CTL_PRST];
   assign sw_wr   = wr_ok && (reg_addr == ADDR_DAT);
   assign sw_adv  = sw_wr || (reg_rd && (reg_addr == ADDR_DAT));
   assign total   = {1'b0, tx_cnt_q} + {1'b0, rx_cnt_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         opcode_q <= '0;
         tx_cnt_q <= '0;
         rx_cnt_q <= '0;
         div_q    <= DIV_W'(DIV_RST);
      end else if (wr_ok) begin
         case (reg_addr)
            ADDR_OPC: opcode_q <= reg_wdata;
            ADDR_CNT: begin
               tx_cnt_q <= reg_wdata[CNT_W-1:0];
               rx_cnt_q <= reg_wdata[2*CNT_W-1:CNT_W];
            end
            ADDR_DIV: div_q <= reg_wdata[DIV_W-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      case (reg_addr)
         ADDR_OPC: reg_rdata = opcode_q;
         ADDR_CNT: reg_rdata = {rx_cnt_q, tx_cnt_q};
         ADDR_DAT: reg_rdata = sw_rdata;
         ADDR_STA: reg_rdata = {done_q, busy_q, {PAD_W{1'b0}}, ptr};
         ADDR_DIV: reg_rdata = {{(DATA_W-DIV_W){1'b0}}, div_q};
         default:  reg_rdata = '0;
      endcase
   end

   // sequencer: next byte selection
   always_comb begin
      nxt_idx    = (state_q == SEQ_OPC) ? '0 : idx_q + 1'b1;
      last       = (nxt_idx == total);
      eng_rd_idx = nxt_idx[PTR_W-1:0];
      ld_en      = 1'b0;
      ld_data    = opcode_q;
      if (state_q == SEQ_IDLE) begin
         ld_en = start;
      end else if (byte_done && !last) begin
         ld_en   = 1'b1;
         ld_data = (nxt_idx < {1'b0, tx_cnt_q}) ? eng_rdata : '1;
      end
   end

   assign eng_wr = (state_q == SEQ_XFER) && byte_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= SEQ_IDLE;
         idx_q    <= '0;
         busy_q   <= 1'b0;
         done_q   <= 1'b0;
         spi_cs_n <= 1'b1;
      end else begin
         case (state_q)
            SEQ_IDLE: if (start) begin
               state_q  <= SEQ_OPC;
               busy_q   <= 1'b1;
               done_q   <= 1'b0;
               spi_cs_n <= 1'b0;
            end
            default: if (byte_done) begin
               if (last) begin
                  state_q  <= SEQ_IDLE;
                  busy_q   <= 1'b0;
                  done_q   <= 1'b1;
                  spi_cs_n <= 1'b1;
               end else begin
                  state_q <= SEQ_XFER;
                  idx_q   <= nxt_idx;
               end
            end
         endcase
      end
   end

   spi_eng_tick #(.DIV_W(DIV_W)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (busy_q),
      .div  (div_q),
      .tick (tick)
   );

   spi_eng_shift #(.DATA_W(DATA_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .load     (ld_en),
      .load_data(ld_data),
      .miso     (spi_miso),
      .sck      (spi_sck),
      .mosi     (spi_mosi),
      .byte_done(byte_done),
      .rx_data  (rx_byte)
   );

   spi_eng_ring #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_ring (
      .clk       (clk),
      .rst_n     (rst_n),
      .sw_clr    (ptr_clr),
      .sw_adv    (sw_adv),
      .sw_wr     (sw_wr),
      .sw_wdata  (reg_wdata),
      .sw_rdata  (sw_rdata),
      .ptr       (ptr),
      .eng_wr    (eng_wr),
      .eng_idx   (idx_q[PTR_W-1:0]),
      .eng_wdata (rx_byte),
      .eng_rd_idx(eng_rd_idx),
      .eng_rdata (eng_rdata)
   );

   // R8: serial clock pulses only inside the chip-select window
   a_r8_sck_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      spi_sck |-> !spi_cs_n);
   // R8: end of busy means chip select released and done raised
   a_r8_done_on_end: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> done_q && spi_cs_n);
   // R7: the final stored byte precedes the chip-select release
   a_r7_store_then_release: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spi_cs_n) |-> $past(eng_wr) || ($past(state_q) == SEQ_OPC));
   // R10: opcode and count hold while a transaction runs
   a_r10_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && reg_wr |=> $stable(opcode_q) && $stable(tx_cnt_q) && $stable(rx_cnt_q));

endmodule

// File: tb/spi_cmd_engine_test.sv
module spi_cmd_engine_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] reg_addr = '0;
   logic       reg_wr = 1'b0;
   logic       reg_rd = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       spi_sck, spi_cs_n, spi_mosi;
   logic       spi_miso = 1'b0;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   spi_cmd_engine uut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
      .spi_miso(spi_miso)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // device model state and scoreboard
   byte unsigned exp_mosi[$];
   int           exp_frame[$];
   logic [7:0]   seed = 8'h00;
   logic [7:0]   ring_m [8];
   int           cur_div = 1;
   int           bitc = 0, bidx = 0, nbytes = 0;
   logic [7:0]   osh = '0, ish = '0;
   bit           first = 0;
   time          t_rise = 0, t_fall = 0;

   function automatic logic [7:0] resp(input logic [7:0] s, input int b);
      return s ^ 8'(b * 29 + 53);
   endfunction

   always @(negedge spi_cs_n) begin
      bitc = 0; bidx = 0; nbytes = 0; first = 0;
      osh = resp(seed, 0);
      spi_miso = osh[7];
   end

   always @(posedge spi_sck) begin
      if (t_fall != 0 && bitc != 0)
         chk("R12 low phase", int'(($time - t_fall) / 8), cur_div + 1);
      t_rise = $time;
      ish = {ish[6:0], spi_mosi};
      bitc++;
      if (bitc == 8) begin
         bitc = 0;
         nbytes++;
         if (exp_mosi.size() == 0) chk("R2 unexpected MOSI byte", ish, 0);
         else chk("R2/R6/R9 MOSI byte", ish, exp_mosi.pop_front());
         bidx++;
         osh = resp(seed, bidx);
         first = 1;
      end
   end

   always @(negedge spi_sck) begin
      if (t_rise != 0) chk("R12 high phase", int'(($time - t_rise) / 8), cur_div + 1);
      t_fall = $time;
      if (spi_cs_n == 1'b0) begin
         if (first) first = 0;
         else osh = {osh[6:0], 1'b0};
         spi_miso = osh[7];
      end
   end

   always @(posedge spi_cs_n) begin
      if (exp_frame.size() > 0)
         chk("R7/R8 bytes inside chip select", nbytes, exp_frame.pop_front());
   end

   always @(posedge spi_sck) begin
      if (spi_cs_n !== 1'b0) chk("R8 SCK outside chip select", 1, 0);
   end

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic wait_done();
      logic [7:0] s;
      s = 8'h40;
      while (s[6]) rd(3'd4, s);
   endtask

   // queue the expected bytes, program registers and start
   task automatic launch(input logic [7:0] opc, input int ntx, input int nrx,
                         input logic [7:0] sd, input logic [7:0] txb [8]);
      seed = sd;
      wr(3'd3, 8'h02);
      for (int k = 0; k < ntx; k++) begin
         wr(3'd2, txb[k]);
         ring_m[k % 8] = txb[k];
      end
      wr(3'd0, opc);
      wr(3'd1, 8'((nrx << 4) | ntx));
      exp_mosi.push_back(opc);
      for (int k = 0; k < ntx; k++) exp_mosi.push_back(txb[k]);
      for (int k = 0; k < nrx; k++) exp_mosi.push_back(8'hFF);
      exp_frame.push_back(1 + ntx + nrx);
      wr(3'd3, 8'h01);
   endtask

   task automatic finish_txn(input string req, input int ntx, input int nrx);
      logic [7:0] v;
      wait_done();
      rd(3'd4, v);
      chk({req, " status after frame (R8, R6 pointer kept)"}, v, 8'h80 | 8'(ntx % 8));
      for (int k = 0; k < ntx + nrx; k++) ring_m[k % 8] = resp(seed, k + 1);
      wr(3'd3, 8'h02);
      for (int s = 0; s < 8; s++) begin
         rd(3'd2, v);
         chk({req, " ring slot"}, v, ring_m[s]);
      end
      rd(3'd4, v);
      chk("R4 pointer wraps after 8 reads", v[2:0], 0);
   endtask

   initial begin
      logic [7:0] v;
      logic [7:0] tb [8];
      repeat (5) @(negedge clk);
      // R1 reset state
      chk("R1 cs_n", spi_cs_n, 1);
      chk("R1 sck", spi_sck, 0);
      rd(3'd4, v);
      chk("R1 status", v, 8'h00);
      rst_n = 1'b1;
      rd(3'd4, v);
      chk("R1 status after release", v, 8'h00);
      rd(3'd5, v);
      chk("R12 divider reset value", v, 8'h01);

      // R4 fill ring, pointer advance and wrap
      for (int k = 0; k < 8; k++) begin
         ring_m[k] = 8'hA0 + 8'(k);
         wr(3'd2, ring_m[k]);
         rd(3'd4, v);
         chk("R4 pointer after write", v[2:0], (k + 1) % 8);
      end
      // R5 pointer reset keeps contents
      wr(3'd3, 8'h02);
      rd(3'd4, v);
      chk("R5 pointer cleared", v[2:0], 0);
      for (int k = 0; k < 8; k++) begin
         rd(3'd2, v);
         chk("R5 contents kept", v, ring_m[k]);
      end

      // R3 count packing readback, opcode readback
      wr(3'd1, 8'h5A);
      rd(3'd1, v);
      chk("R3 count readback", v, 8'h5A);
      wr(3'd0, 8'h3C);
      rd(3'd0, v);
      chk("R2 opcode readback", v, 8'h3C);

      // R7 transmit count zero, three response bytes
      for (int k = 0; k < 8; k++) tb[k] = 8'h00;
      launch(8'h9F, 0, 3, 8'h11, tb);
      finish_txn("R7 tx0 rx3", 0, 3);

      // R6 echo slots then response
      tb[0] = 8'h03; tb[1] = 8'h12; tb[2] = 8'hC4;
      launch(8'h0B, 3, 4, 8'h5E, tb);
      finish_txn("R6 tx3 rx4", 3, 4);

      // R12 fastest divider
      wr(3'd5, 8'h00);
      cur_div = 0;
      tb[0] = 8'h81; tb[1] = 8'h7E;
      launch(8'h05, 2, 2, 8'hB2, tb);
      finish_txn("R12 divider 0", 2, 2);

      // R11 overflow: 11 bytes after opcode
      wr(3'd5, 8'h02);
      cur_div = 2;
      for (int k = 0; k < 5; k++) tb[k] = 8'h30 + 8'(k * 7);
      launch(8'hEB, 5, 6, 8'hC7, tb);
      finish_txn("R11 overflow", 5, 6);

      // R10 writes during busy are ignored
      wr(3'd5, 8'h03);
      cur_div = 3;
      launch(8'h9E, 0, 8, 8'h29, tb);
      rd(3'd4, v);
      chk("R8 busy set after start", v[7:6], 2'b01);
      wr(3'd0, 8'hEE);
      wr(3'd1, 8'h00);
      wr(3'd2, 8'h77);
      wr(3'd5, 8'h00);
      wr(3'd3, 8'h01);
      rd(3'd4, v);
      chk("R10 pointer unchanged by busy data write", v[2:0], 0);
      finish_txn("R10 tx0 rx8", 0, 8);
      rd(3'd0, v);
      chk("R10 opcode ignored while busy", v, 8'h9E);
      rd(3'd1, v);
      chk("R10 count ignored while busy", v, 8'h80);
      rd(3'd5, v);
      chk("R10 divider ignored while busy", v, 8'h03);
      repeat (20) @(negedge clk);
      chk("R10 start while busy did not relaunch", spi_cs_n, 1);
      chk("R2 scoreboard drained", exp_mosi.size(), 0);

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule